// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using the recent outcomes of all branches. A shift register keeps the last few branch outcomes, newest in bit 0. The fetch stage presents a branch address. The block forms a table index from that history, either alone or XORed with a slice of the address. It reads a 2-bit saturating counter at that index and returns the counter's upper bit as the guess. The result comes out in the same cycle, combinationally. The index it used is also returned, so the pipeline can carry it along with the branch.

When the branch resolves, the pipeline hands back the carried index and the real outcome. The counter at that index moves one step toward the outcome, and the outcome is shifted into the history. Because the stored index is used, training reaches the entry that made the guess even if the history has moved on since then. A parameter selects plain history indexing or XOR indexing. The history length and the log2 of the table size are one shared parameter.

Top module: `gshare_predictor`

## Requirements
- R1: After reset every counter holds 2'b10 (weakly taken), so every prediction is taken, and the history register is zero.
- R2: With `USE_XOR`=1, `predIdx` equals the history XOR `predPc[PC_LSB +: HIST_BITS]`. With `USE_XOR`=0, `predIdx` equals the history.
- R3: `predTaken` is 1 when the addressed counter is 2'b10 or 2'b11, and 0 when it is 2'b01 or 2'b00.
- R4: A taken update raises the counter at `updIdx` by one and holds it at 2'b11 once it is there.
- R5: A not-taken update lowers the counter at `updIdx` by one and holds it at 2'b00 once it is there.
- R6: From 2'b11, one not-taken update leaves the prediction taken; a second consecutive not-taken update turns it to not taken.
- R7: Each update shifts `updTaken` into history bit 0 and drops the oldest bit; in a cycle with no update the history keeps its value.
- R8: Training changes only the entry named by `updIdx`, whatever the current history is.
- R9: If a prediction and an update address the same entry in one cycle, the prediction reflects the counter value from before the update.
- R10: `predTaken` and `predIdx` depend combinationally on `predPc` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| predPc | input | PC_W | Address of the branch being predicted |
| predTaken | output | 1 | Guessed direction, 1 = taken |
| predIdx | output | HIST_BITS | Table index used for this guess |
| updValid | input | 1 | A resolved branch is presented this cycle |
| updTaken | input | 1 | Actual outcome of the resolved branch |
| updIdx | input | HIST_BITS | Index returned from prediction time |

## Verification
A prediction and a training update can fall in the same cycle on the same table entry. The bench provokes this on purpose: it builds the predict address from the model history so that its index equals the update index. It then checks that the guess reflects the counter before the write and that the next cycle shows the new value. History shifting and prediction also overlap in every updating cycle, so each cycle's `predIdx` is judged against the history the model holds before that edge. A long run of random addresses and outcomes is compared against the same model.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic       wrEn;
    logic [1:0] wrVal;
    logic       shiftEn;
    logic       shiftBit;
  } trainStrobe_t;

  localparam logic [1:0] CTR_STRONG_NT = 2'b00;
  localparam logic [1:0] CTR_WEAK_T    = 2'b10;
  localparam logic [1:0] CTR_STRONG_T  = 2'b11;

endpackage

// File: rtl/gshare_dp.sv
module gshare_dp
  import gshare_pkg::*;
#(
  parameter int HIST_BITS = 6,
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter bit USE_XOR   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PC_W-1:0]      predPc,
  input  logic [HIST_BITS-1:0] updIdx,
  input  trainStrobe_t         strobe,
  output logic [HIST_BITS-1:0] predIdx,
  output logic [1:0]           predCtr,
  output logic [1:0]           updCtr,
  output logic [HIST_BITS-1:0] histQ
);

  localparam int ENTRIES = 1 << HIST_BITS;

  logic [1:0] ctrTab [ENTRIES];
  logic       unusedPcBits;

  assign unusedPcBits = ^predPc;

  // R2: index hash selected by parameter
  generate
    if (USE_XOR) begin : gXorIdx
      assign predIdx = histQ ^ predPc[PC_LSB +: HIST_BITS];
    end else begin : gHistIdx
      assign predIdx = histQ;
    end
  endgenerate

  // R10, R9: combinational read of the stored (pre-write) value
  assign predCtr = ctrTab[predIdx];
  assign updCtr  = ctrTab[updIdx];

  // R7: history shift, newest outcome in bit 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histQ <= '0;
    end else if (strobe.shiftEn) begin
      histQ <= {histQ[HIST_BITS-2:0], strobe.shiftBit};
    end
  end

  // R1, R8: counter table, written only at the returned index
  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : gCtr
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          ctrTab[e] <= CTR_WEAK_T;
        end else if (strobe.wrEn && (updIdx == HIST_BITS'(e))) begin
          ctrTab[e] <= strobe.wrVal;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gshare_ctrl.sv
module gshare_ctrl
  import gshare_pkg::*;
(
  input  logic         updValid,
  input  logic         updTaken,
  input  logic [1:0]   updCtr,
  input  logic [1:0]   predCtr,
  output trainStrobe_t strobe,
  output logic         predTaken
);

  logic [1:0] nextCtr;

  // R4, R5: saturating step toward the outcome
  always_comb begin
    if (updTaken) begin
      nextCtr = (updCtr == CTR_STRONG_T) ? CTR_STRONG_T : updCtr + 2'd1;
    end else begin
      nextCtr = (updCtr == CTR_STRONG_NT) ? CTR_STRONG_NT : updCtr - 2'd1;
    end
  end

  always_comb begin
    strobe.wrEn     = updValid;
    strobe.wrVal    = nextCtr;
    strobe.shiftEn  = updValid;
    strobe.shiftBit = updTaken;
  end

  // R3: upper counter bit is the direction
  assign predTaken = predCtr[1];

endmodule

// File: rtl/gshare_predictor.sv
module gshare_predictor
  import gshare_pkg::*;
#(
  parameter int HIST_BITS = 6,
  parameter int PC_W      = 32,
  parameter int PC_LSB    = 2,
  parameter bit USE_XOR   = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PC_W-1:0]      predPc,
  output logic                 predTaken,
  output logic [HIST_BITS-1:0] predIdx,
  input  logic                 updValid,
  input  logic                 updTaken,
  input  logic [HIST_BITS-1:0] updIdx
);

  trainStrobe_t         trainStb;
  logic [1:0]           predCtr;
  logic [1:0]           updCtr;
  logic [HIST_BITS-1:0] histQ;

  gshare_dp #(
    .HIST_BITS(HIST_BITS),
    .PC_W     (PC_W),
    .PC_LSB   (PC_LSB),
    .USE_XOR  (USE_XOR)
  ) uDp (
    .clk    (clk),
    .rstN   (rstN),
    .predPc (predPc),
    .updIdx (updIdx),
    .strobe (trainStb),
    .predIdx(predIdx),
    .predCtr(predCtr),
    .updCtr (updCtr),
    .histQ  (histQ)
  );

  gshare_ctrl uCtrl (
    .updValid (updValid),
    .updTaken (updTaken),
    .updCtr   (updCtr),
    .predCtr  (predCtr),
    .strobe   (trainStb),
    .predTaken(predTaken)
  );

endmodule

// File: rtl/gshare_chk.sv
module gshare_chk
  import gshare_pkg::*;
#(
  parameter int HIST_BITS = 6
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 updValid,
  input logic                 updTaken,
  input logic [HIST_BITS-1:0] histQ,
  input trainStrobe_t         trainStb,
  input logic [1:0]           updCtr
);

  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> histQ == {$past(histQ[HIST_BITS-2:0]), $past(updTaken)}); // R7

  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(histQ)); // R7

  AST_WRITE_NEEDS_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    trainStb.wrEn |-> updValid); // R8

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (trainStb.wrEn && updTaken) |->
      ({1'b0, trainStb.wrVal} >= {1'b0, updCtr}) &&
      ({1'b0, trainStb.wrVal} - {1'b0, updCtr} <= 3'd1)); // R4

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (trainStb.wrEn && !updTaken) |->
      ({1'b0, updCtr} >= {1'b0, trainStb.wrVal}) &&
      ({1'b0, updCtr} - {1'b0, trainStb.wrVal} <= 3'd1)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (trainStb.wrEn && updTaken && updCtr == CTR_STRONG_T) |->
      trainStb.wrVal == CTR_STRONG_T); // R4

endmodule

bind gshare_predictor gshare_chk #(.HIST_BITS(HIST_BITS)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .updValid(updValid),
  .updTaken(updTaken),
  .histQ   (histQ),
  .trainStb(trainStb),
  .updCtr  (updCtr)
);

// File: tb/tb_gshare_predictor.sv
module tb_gshare_predictor;

  localparam int HB  = 6;
  localparam int PCW = 32;
  localparam int LSB = 2;
  localparam int NE  = 1 << HB;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [PCW-1:0] predPc = '0;
  logic           predTaken;
  logic [HB-1:0]  predIdx;
  logic           updValid = 1'b0;
  logic           updTaken = 1'b0;
  logic [HB-1:0]  updIdx = '0;

  always #5 clk = ~clk;

  gshare_predictor #(.HIST_BITS(HB), .PC_W(PCW), .PC_LSB(LSB), .USE_XOR(1'b1)) dut (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predTaken(predTaken),
    .predIdx(predIdx), .updValid(updValid), .updTaken(updTaken), .updIdx(updIdx)
  );

  typedef struct {
    logic          taken;
    logic [HB-1:0] idx;
    string         tag;
  } exp_t;

  exp_t          expQ[$];
  event          sampleEv;
  int            total = 0;
  int            bad = 0;
  logic [1:0]    mCtr [NE];
  logic [HB-1:0] mHist;

  function automatic logic [PCW-1:0] pcFor(input logic [HB-1:0] idx);
    logic [PCW-1:0] p;
    p = '0;
    p[LSB +: HB] = idx ^ mHist;
    return p;
  endfunction

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      @(sampleEv);
      while (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        total++;
        if (predTaken !== e.taken) begin
          bad++;
          $display("FAIL %s predTaken act=%0b exp=%0b", e.tag, predTaken, e.taken);
        end
        total++;
        if (predIdx !== e.idx) begin
          bad++;
          $display("FAIL %s predIdx act=%0h exp=%0h", e.tag, predIdx, e.idx);
        end
      end
    end
  end

  // driver: one cycle of stimulus, expected values from the model
  task automatic cyc(input logic [PCW-1:0] pc, input logic uv, input logic ut,
                     input logic [HB-1:0] ui, input string tag);
    exp_t e;
    @(negedge clk);
    predPc = pc; updValid = uv; updTaken = ut; updIdx = ui;
    #1;
    e.idx   = mHist ^ pc[LSB +: HB];
    e.taken = mCtr[e.idx][1];
    e.tag   = tag;
    expQ.push_back(e);
    ->sampleEv;
    #1;
    if (uv) begin
      if (ut) mCtr[ui] = (mCtr[ui] == 2'b11) ? 2'b11 : mCtr[ui] + 2'd1;
      else    mCtr[ui] = (mCtr[ui] == 2'b00) ? 2'b00 : mCtr[ui] - 2'd1;
      mHist = {mHist[HB-2:0], ut};
    end
  endtask

  initial begin
    #(200000 * 10);
    total++;
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NE; i++) mCtr[i] = 2'b10;
    mHist = '0;
    repeat (3) @(posedge clk);
    #2 rstN = 1'b1;

    // R1: reset state, pc 0 exposes history, all entries weakly taken
    cyc('0, 1'b0, 1'b0, '0, "R1");
    cyc(32'h0000_00a4, 1'b0, 1'b0, '0, "R1");

    // R9 / R3 / R5: collide predict and update on entry 5
    cyc(pcFor(6'd5), 1'b1, 1'b0, 6'd5, "R9");
    cyc(pcFor(6'd5), 1'b1, 1'b0, 6'd5, "R9");
    cyc(pcFor(6'd5), 1'b0, 1'b0, '0, "R3");
    cyc(pcFor(6'd5), 1'b1, 1'b0, 6'd5, "R5");
    cyc(pcFor(6'd5), 1'b0, 1'b0, '0, "R5");
    cyc(pcFor(6'd5), 1'b1, 1'b1, 6'd5, "R5");
    cyc(pcFor(6'd5), 1'b0, 1'b0, '0, "R5");

    // R4 / R6: saturate entry 9 high then two not-taken
    cyc('0, 1'b1, 1'b1, 6'd9, "R7");
    cyc('0, 1'b1, 1'b1, 6'd9, "R7");
    cyc('0, 1'b1, 1'b1, 6'd9, "R7");
    cyc(pcFor(6'd9), 1'b0, 1'b0, '0, "R4");
    cyc(pcFor(6'd9), 1'b1, 1'b0, 6'd9, "R6");
    cyc(pcFor(6'd9), 1'b0, 1'b0, '0, "R6");
    cyc(pcFor(6'd9), 1'b1, 1'b0, 6'd9, "R6");
    cyc(pcFor(6'd9), 1'b0, 1'b0, '0, "R6");

    // R8: train entry 20 while history moves; neighbour 21 untouched
    cyc('0, 1'b1, 1'b0, 6'd20, "R8");
    cyc('0, 1'b1, 1'b0, 6'd20, "R8");
    cyc(pcFor(6'd20), 1'b0, 1'b0, '0, "R8");
    cyc(pcFor(6'd21), 1'b0, 1'b0, '0, "R8");

    // R7: idle cycles hold history
    cyc('0, 1'b0, 1'b0, '0, "R7");
    cyc('0, 1'b0, 1'b0, '0, "R7");

    // R2 / R10: random traffic
    for (int k = 0; k < 600; k++) begin
      logic [PCW-1:0] rp;
      logic [HB-1:0]  ri;
      rp = $urandom();
      ri = HB'($urandom_range(0, 15));
      cyc(rp, 1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0), ri, "R2");
    end

    #5;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule